// File: doc/BRIEF.md
# Instruction Fetch and Next-Address Unit

This block holds the program counter of a single-cycle processor, presents it to a small word-addressed instruction ROM and selects the address for the following cycle. The ROM read is combinational, so the instruction word for the current address is available in the same cycle. The surrounding datapath decodes that word, compares two register operands and feeds back three signals: a branch-select flag, the result of the equality comparison, and the 16-bit offset field of the instruction.

On every rising clock edge the counter moves to the next 4-byte word. It moves to a branch target instead only when the branch-select flag and the equality flag are both high. The target is the sequential address plus the sign-extended offset scaled by four. All address arithmetic is 32 bits wide and wraps. The ROM contents are generated from a formula, so the block needs no external file.

Top module: `ifetch_unit`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `pc_o` is 0 after that edge, whatever the other inputs are.
- R2: When `br_sel` is 0, the next `pc_o` is the current `pc_o` + 4, whatever the values of `br_eq` and `ofs_imm`.
- R3: When `br_sel` is 1 and `br_eq` is 0, the next `pc_o` is the current `pc_o` + 4, and `ofs_imm` has no effect.
- R4: When `br_sel` and `br_eq` are both 1, the next `pc_o` is `pc_o` + 4 + (sign-extended `ofs_imm` shifted left by 2). Bit 15 of `ofs_imm` is the sign bit.
- R5: A taken branch with a negative offset (`ofs_imm` bit 15 set) moves `pc_o` backwards.
- R6: A taken branch with `ofs_imm` = 0 lands at `pc_o` + 4.
- R7: The address arithmetic wraps modulo 2^32. A taken branch from 0 with offset 0xFFFE gives 0xFFFFFFFC, and the step after that returns to 0.
- R8: `instr_o` equals the ROM word at index k = `pc_o`[ADDR_W+1:2]. The word at index k is {16'hC3A5, k8, ~k8}, where k8 is k truncated or zero-extended to 8 bits.
- R9: `instr_o` changes in the same cycle as `pc_o`, with no register between them.
- R10: `pc_o`[1:0] is always 0.
- R11: Bits of `pc_o` above ADDR_W+1 do not affect `instr_o`, so the ROM repeats across the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| br_sel | input | 1 | High when the current instruction is a conditional branch |
| br_eq | input | 1 | Equality result from the operand comparator |
| ofs_imm | input | 16 | Signed word offset taken from the current instruction |
| pc_o | output | 32 | Current program counter, a byte address |
| instr_o | output | 32 | Instruction word fetched at `pc_o` |

## Verification
The hardest case to reach from the ports is the wrap of the address across 2^32. The counter starts at 0 and has to be pushed to the top of the address space. The stimulus does this with a taken branch whose offset is small and negative, issued at address 0. This lands at 0xFFFFFFFC, and one sequential step then wraps back to 0. A large positive branch then moves the counter past the ROM's index range, to show that fetch aliasing follows only the index bits.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int XLEN = 32;
  localparam int OFSW = 16;
  typedef logic [XLEN-1:0] addr_t;
  typedef logic [XLEN-1:0] word_t;

  // Generated ROM contents: a fixed tag followed by the index and its complement.
  function automatic word_t rom_word(input logic [7:0] k);
    return {16'hC3A5, k, ~k};
  endfunction
endpackage

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg
  import ifu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  addr_t d,
  output addr_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
  import ifu_pkg::*;
(
  input  addr_t           pc,
  input  logic            br_sel,
  input  logic            br_eq,
  input  logic [OFSW-1:0] ofs_imm,
  output addr_t           nxt
);
  localparam int EXT = XLEN - OFSW - 2;

  addr_t seq_pc;
  addr_t ofs_bytes;
  addr_t tgt_pc;
  logic  take;

  always_comb begin
    seq_pc    = pc + addr_t'(4);
    ofs_bytes = {{EXT{ofs_imm[OFSW-1]}}, ofs_imm, 2'b00};
    tgt_pc    = seq_pc + ofs_bytes;
    take      = br_sel & br_eq;
    nxt       = take ? tgt_pc : seq_pc;
  end
endmodule

// File: rtl/ifu_rom.sv
module ifu_rom
  import ifu_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  addr_t addr,
  output word_t data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int IDX_HI = ADDR_W + 1;

  word_t             mem [DEPTH];
  logic [ADDR_W-1:0] idx;
  logic              unused_addr_bits;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign mem[g] = rom_word(8'(g));
  end

  assign idx              = addr[IDX_HI:2];
  assign unused_addr_bits = ^{addr[XLEN-1:IDX_HI+1], addr[1:0]};
  assign data             = mem[idx];
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
  import ifu_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        br_sel,
  input  logic        br_eq,
  input  logic [15:0] ofs_imm,
  output logic [31:0] pc_o,
  output logic [31:0] instr_o
);
  addr_t pc_q;
  addr_t pc_d;

  ifu_pc_reg u_pc (
    .clk (clk),
    .rst (rst),
    .d   (pc_d),
    .q   (pc_q)
  );

  ifu_next_pc u_npc (
    .pc      (pc_q),
    .br_sel  (br_sel),
    .br_eq   (br_eq),
    .ofs_imm (ofs_imm),
    .nxt     (pc_d)
  );

  ifu_rom #(.ADDR_W(ADDR_W)) u_rom (
    .addr (pc_q),
    .data (instr_o)
  );

  assign pc_o = pc_q;
endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk #(
  parameter int ADDR_W = 6
) (
  input logic        clk,
  input logic        rst,
  input logic        br_sel,
  input logic        br_eq,
  input logic [15:0] ofs_imm,
  input logic [31:0] pc_o,
  input logic [31:0] instr_o
);
  logic [7:0] k8;
  assign k8 = 8'(pc_o[ADDR_W+1:2]);

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (pc_o == 32'd0));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    !(br_sel && br_eq) |=> (pc_o == $past(pc_o) + 32'd4));

  assert_taken_target_R4: assert property (@(posedge clk) disable iff (rst)
    (br_sel && br_eq) |=> (pc_o == $past(pc_o) + 32'd4 +
      {{14{$past(ofs_imm[15])}}, $past(ofs_imm), 2'b00}));

  assert_aligned_R10: assert property (@(posedge clk) disable iff (rst)
    pc_o[1:0] == 2'b00);

  assert_fetch_word_R8: assert property (@(posedge clk) disable iff (rst)
    instr_o == {16'hC3A5, k8, ~k8});
endmodule

bind ifetch_unit ifetch_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .br_sel  (br_sel),
  .br_eq   (br_eq),
  .ofs_imm (ofs_imm),
  .pc_o    (pc_o),
  .instr_o (instr_o)
);

// File: tb/tb_ifetch_unit.sv
`timescale 1ns/1ps
module tb_ifetch_unit;
  localparam int ADDR_W = 6;
  localparam int NVEC   = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_sel = 1'b0;
  logic        br_eq = 1'b0;
  logic [15:0] ofs_imm = 16'h0;
  logic [31:0] pc_o;
  logic [31:0] instr_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ifetch_unit #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .br_sel(br_sel), .br_eq(br_eq),
    .ofs_imm(ofs_imm), .pc_o(pc_o), .instr_o(instr_o)
  );

  // Each entry: {br_sel, br_eq, ofs_imm, expected next pc}
  typedef struct packed {
    logic        sel;
    logic        eq;
    logic [15:0] imm;
    logic [31:0] exp_pc;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 16'h0000, 32'h0000_0004},  // R2
    '{1'b0, 1'b1, 16'h0010, 32'h0000_0008},  // R2: br_eq without br_sel
    '{1'b1, 1'b0, 16'h0040, 32'h0000_000C},  // R3: not equal
    '{1'b1, 1'b1, 16'h0004, 32'h0000_0020},  // R4: forward
    '{1'b1, 1'b1, 16'h0000, 32'h0000_0024},  // R6: zero offset
    '{1'b1, 1'b1, 16'hFFFC, 32'h0000_0018},  // R5: backward
    '{1'b0, 1'b0, 16'hFFFF, 32'h0000_001C},  // R2
    '{1'b1, 1'b1, 16'hFFF9, 32'h0000_0004},  // R5: backward
    '{1'b1, 1'b1, 16'hFFFE, 32'h0000_0000},  // R5: back to 0
    '{1'b1, 1'b1, 16'hFFFE, 32'hFFFF_FFFC},  // R7: below zero
    '{1'b0, 1'b0, 16'h0000, 32'h0000_0000},  // R7: wrap over top
    '{1'b1, 1'b1, 16'h7FFF, 32'h0002_0000}   // R4: largest forward
  };

  function automatic logic [31:0] model_word(input logic [31:0] a);
    logic [7:0] k;
    k = {2'b00, a[7:2]};
    return {16'hC3A5, k, ~k};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // Reset state, taken-branch inputs present to show they are overridden.
    br_sel = 1'b1; br_eq = 1'b1; ofs_imm = 16'h0100;
    check("R1", pc_o, 32'h0);
    check("R8", instr_o, model_word(32'h0));
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      br_sel  = VECS[i].sel;
      br_eq   = VECS[i].eq;
      ofs_imm = VECS[i].imm;
      #1;
      check("R8/R9 fetch", instr_o, model_word(pc_o));
      check("R10 align", {30'h0, pc_o[1:0]}, 32'h0);
      @(posedge clk);
      @(negedge clk);
      check("R2/R3/R4/R5/R6/R7 next pc", pc_o, VECS[i].exp_pc);
    end
    // R11: pc 0x20000 aliases to ROM index 0.
    check("R11 alias", instr_o, 32'hC3A5_00FF);
    // R1: reset mid-run overrides a taken branch.
    br_sel = 1'b1; br_eq = 1'b1; ofs_imm = 16'h0008;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-run", pc_o, 32'h0);
    rst = 1'b0; br_sel = 1'b0; br_eq = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2 after reset", pc_o, 32'h4);
    check("R8 after reset", instr_o, 32'hC3A5_01FE);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule